// File: doc/BRIEF.md
# Two-Joystick Game Port

This block is an I/O-mapped port for two joysticks. A host read at the configured base address returns one status byte. The byte holds four button levels and four axis levels. Each axis level is the output of an external comparator on an RC timing pin. All eight inputs pass through a synchronizer before they reach the read path.

A write to the same address stores nothing. When the write strobe falls, the block drives a discharge output for a set number of clock cycles. That pulse empties the axis capacitors so that a new timing measurement can begin. A second write during a pulse starts the count again.

The port has a single enable bit. Two configuration registers hold that bit and mirror each other: an activate register and bit 2 of a power-control register. While the enable is clear, the port answers no read and starts no pulse.

Top module: `gameport_if`

## Requirements
- R1: Status byte bits 7..4 are, in order, joystick 2 button 2, joystick 2 button 1, joystick 1 button 2 and joystick 1 button 1, taken from `btn_in[3]`..`btn_in[0]`.
- R2: Status byte bits 3..0 are, in order, joystick 2 Y, joystick 2 X, joystick 1 Y and joystick 1 X, taken from `axis_in[3]`..`axis_in[0]`.
- R3: An input change reaches the read data after exactly two rising clock edges, and not after one.
- R4: `io_rdata` carries the status byte only while `io_rd` is high, `io_addr` equals `base_addr` and the port is enabled. At all other times it is 00h.
- R5: A port write leaves the readable status byte unchanged.
- R6: No discharge occurs while the write strobe is held. `rc_discharge` goes high on the first rising edge that samples the strobe low after a decoded write.
- R7: One pulse keeps `rc_discharge` high for exactly `PULSE_CYC` clock cycles.
- R8: A write whose trailing edge falls during a pulse reloads the count, so the output stays high for `PULSE_CYC` cycles from that new edge.
- R9: A write to any address other than `base_addr` starts no pulse.
- R10: Writing the activate register (`act_wr`/`act_wdata`) or power-control bit 2 (`pwr_wr`/`pwr_en_bit`) sets the shared enable `port_active`. If both are written in the same cycle, the activate value wins.
- R11: While `port_active` is 0, reads return 00h and writes start no pulse. Clearing the enable during a pulse ends the pulse one cycle later.
- R12: After reset, `port_active`, `rc_discharge` and `io_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr | input | ADDR_W | Configured base I/O address of the port |
| io_addr | input | ADDR_W | Host I/O address |
| io_rd | input | 1 | Host read strobe, active high |
| io_wr | input | 1 | Host write strobe, active high (level) |
| io_rdata | output | 8 | Read data, 00h when the read is not decoded |
| act_wr | input | 1 | Write enable for the activate register |
| act_wdata | input | 1 | Activate value to write |
| pwr_wr | input | 1 | Write enable for the power-control register |
| pwr_en_bit | input | 1 | Bit 2 of the power-control write data |
| port_active | output | 1 | Shared enable held by both registers |
| btn_in | input | 4 | Raw button levels |
| axis_in | input | 4 | Raw axis comparator levels |
| rc_discharge | output | 1 | Discharge drive for the RC timing pins |

## Verification
Two functions can act in the same cycle. One is a discharge pulse already in progress. The other is either a new write trailing edge or a change to the enable. The bench starts a second write on the cycle right after a pulse begins. It then checks that the output stays high for a full `PULSE_CYC` cycles counted from the second edge, which is longer than what remains of the first pulse. It also clears the enable partway through a pulse and checks that the output drops exactly one cycle later. In the register path, a write to the activate register and a write to the power-control register land on the same edge with opposite values, and the bench checks that the activate value is the one kept.

// File: rtl/gp_pkg.sv
// Package: shared types for the game port.
// Assumes: button and axis groups are four bits each, with joystick 2 in the upper bits.
package gp_pkg;

    localparam int GP_GROUP_W = 4;

    typedef struct packed {
        logic [GP_GROUP_W-1:0] btn;   // bits 7..4
        logic [GP_GROUP_W-1:0] axis;  // bits 3..0
    } gp_status_t;

endpackage

// File: rtl/gp_sync.sv
// Module: multi-stage synchronizer for a bus of independent level inputs.
// Assumes: each bit is a slow level; no coherence across bits is needed.
module gp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: move the value one stage along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= d_in;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/gp_shadow_en.sv
// Module: the port enable bit, held in common by the activate register and
// bit 2 of the power-control register.
// Assumes: if both registers are written in one cycle, the activate write wins.
module gp_shadow_en (
    input  logic clk,
    input  logic rst_n,
    input  logic act_wr,
    input  logic act_wdata,
    input  logic pwr_wr,
    input  logic pwr_en_bit,
    output logic active
);

    // Purpose: update the shared enable from whichever register is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (act_wr) begin
            active <= act_wdata;
        end else if (pwr_wr) begin
            active <= pwr_en_bit;
        end
    end

endmodule

// File: rtl/gp_discharge.sv
// Module: detects the falling edge of a decoded write strobe and drives the
// discharge pulse for PULSE_CYC cycles.
// Assumes: wr_hit is the strobe already qualified by address and enable;
// wr_strobe is the raw strobe level.
module gp_discharge #(
    parameter int PULSE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic wr_hit,
    input  logic wr_strobe,
    output logic discharge
);

    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYC);

    logic             hit_q;
    logic             trail;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: remember whether the previous cycle held a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= wr_hit;
        end
    end

    assign trail = hit_q & ~wr_strobe;

    // Purpose: load, reload or count down the pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable) begin
            cnt_q <= '0;
        end else if (trail) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign discharge = (cnt_q != '0);

endmodule

// File: rtl/gameport_if.sv
// Module: top of the two-joystick game port. It decodes host reads and
// writes at base_addr, returns the synchronized status byte and starts RC
// discharge pulses on write trailing edges.
// Assumes: host strobes are synchronous to clk; base_addr is static while in use.
module gameport_if #(
    parameter int ADDR_W    = 16,
    parameter int PULSE_CYC = 64,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [7:0]        io_rdata,
    input  logic              act_wr,
    input  logic              act_wdata,
    input  logic              pwr_wr,
    input  logic              pwr_en_bit,
    output logic              port_active,
    input  logic [3:0]        btn_in,
    input  logic [3:0]        axis_in,
    output logic              rc_discharge
);

    import gp_pkg::*;

    localparam int STAT_W = 2 * GP_GROUP_W;

    gp_status_t       raw_stat;
    logic [STAT_W-1:0] sync_stat;
    logic              addr_hit;
    logic              wr_hit;

    assign raw_stat.btn  = btn_in;
    assign raw_stat.axis = axis_in;

    gp_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_stat),
        .d_out (sync_stat)
    );

    gp_shadow_en u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_wr     (act_wr),
        .act_wdata  (act_wdata),
        .pwr_wr     (pwr_wr),
        .pwr_en_bit (pwr_en_bit),
        .active     (port_active)
    );

    assign addr_hit = (io_addr == base_addr);
    assign wr_hit   = io_wr & addr_hit & port_active;

    gp_discharge #(.PULSE_CYC(PULSE_CYC)) u_dis (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (port_active),
        .wr_hit    (wr_hit),
        .wr_strobe (io_wr),
        .discharge (rc_discharge)
    );

    // Purpose: drive the status byte for a decoded read and zero otherwise.
    always_comb begin
        io_rdata = 8'h00;
        if (io_rd && addr_hit && port_active) begin
            io_rdata = sync_stat;
        end
    end

endmodule

// File: rtl/gameport_if_chk.sv
// Module: checker for gameport_if, attached with bind.
// Assumes: it sees only the ports of the top module.
module gameport_if_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] base_addr,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_rdata,
    input logic              act_wr,
    input logic              act_wdata,
    input logic              pwr_wr,
    input logic              pwr_en_bit,
    input logic              port_active,
    input logic              rc_discharge
);

    // R4
    rd_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rdata != 8'h00) |-> (io_rd && io_addr == base_addr && port_active));

    // R6
    trail_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_discharge) |-> (!$past(io_wr) && $past(io_wr, 2)));

    // R9
    launch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_discharge) |-> ($past(io_addr, 2) == $past(base_addr, 2)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_active |=> !rc_discharge);

    // R10
    act_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_wr |=> (port_active == $past(act_wdata)));

    // R10
    pwr_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_wr && !act_wr) |=> (port_active == $past(pwr_en_bit)));

endmodule

bind gameport_if gameport_if_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_addr    (base_addr),
    .io_addr      (io_addr),
    .io_rd        (io_rd),
    .io_wr        (io_wr),
    .io_rdata     (io_rdata),
    .act_wr       (act_wr),
    .act_wdata    (act_wdata),
    .pwr_wr       (pwr_wr),
    .pwr_en_bit   (pwr_en_bit),
    .port_active  (port_active),
    .rc_discharge (rc_discharge)
);

// File: tb/sim_gameport_if.sv
// Bench for gameport_if: a vector table for the status byte, then directed tests.
module sim_gameport_if;

    localparam int AW = 16;
    localparam int P  = 16;
    localparam logic [AW-1:0] BASE = 16'h0201;

    // Each entry: {btn_in, axis_in, expected byte}
    localparam logic [15:0] VEC [6] = '{
        {4'b1000, 4'b0000, 8'h80},
        {4'b0100, 4'b0000, 8'h40},
        {4'b0011, 4'b0000, 8'h30},
        {4'b0000, 4'b1000, 8'h08},
        {4'b0000, 4'b0101, 8'h05},
        {4'b1010, 4'b0110, 8'hA6}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] io_addr = '0;
    logic          io_rd = 1'b0;
    logic          io_wr = 1'b0;
    logic [7:0]    io_rdata;
    logic          act_wr = 1'b0;
    logic          act_wdata = 1'b0;
    logic          pwr_wr = 1'b0;
    logic          pwr_en_bit = 1'b0;
    logic          port_active;
    logic [3:0]    btn_in = '0;
    logic [3:0]    axis_in = '0;
    logic          rc_discharge;

    int n_total = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    gameport_if #(.ADDR_W(AW), .PULSE_CYC(P)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_addr    (BASE),
        .io_addr      (io_addr),
        .io_rd        (io_rd),
        .io_wr        (io_wr),
        .io_rdata     (io_rdata),
        .act_wr       (act_wr),
        .act_wdata    (act_wdata),
        .pwr_wr       (pwr_wr),
        .pwr_en_bit   (pwr_en_bit),
        .port_active  (port_active),
        .btn_in       (btn_in),
        .axis_in      (axis_in),
        .rc_discharge (rc_discharge)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    // Read at an address on a negedge; sample shortly after.
    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    // One-cycle write strobe; the next posedge sees the trailing edge.
    task automatic wr(input logic [AW-1:0] a);
        @(negedge clk);
        io_addr = a; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // Count consecutive negedges with the discharge output high.
    task automatic count_high(output int n);
        n = 0;
        for (int i = 0; i < 4 * P; i++) begin
            @(negedge clk);
            if (!rc_discharge) break;
            n++;
        end
    endtask

    task automatic set_act(input logic v);
        @(negedge clk);
        act_wr = 1'b1; act_wdata = v;
        @(negedge clk);
        act_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        report();
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;

        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 port_active", port_active, 0);
        chk("R12 rc_discharge", rc_discharge, 0);
        io_rd = 1'b1; io_addr = BASE;
        #1 chk("R12 io_rdata", io_rdata, 0);
        io_rd = 1'b0;
        rst_n = 1'b1;

        // R10: the power-control bit sets the enable
        @(negedge clk);
        pwr_wr = 1'b1; pwr_en_bit = 1'b1;
        @(negedge clk);
        pwr_wr = 1'b0;
        chk("R10 pwr set", port_active, 1);

        // R1 R2: vector table walk
        for (int v = 0; v < 6; v++) begin
            btn_in = VEC[v][15:12]; axis_in = VEC[v][11:8];
            repeat (3) @(negedge clk);
            rd(BASE, d);
            chk("R1/R2 status byte", d, VEC[v][7:0]);
        end

        // R3: two-edge synchronizer latency
        @(negedge clk);
        btn_in = 4'h0; axis_in = 4'h0;
        repeat (3) @(negedge clk);
        btn_in = 4'h1;
        @(negedge clk);
        io_addr = BASE; io_rd = 1'b1;
        #1 chk("R3 after one edge", io_rdata, 8'h00);
        @(negedge clk);
        #1 chk("R3 after two edges", io_rdata, 8'h10);
        io_rd = 1'b0;

        // R4: a read at another address, and no read strobe
        rd(BASE + 1, d);
        chk("R4 wrong address", d, 0);
        @(negedge clk);
        io_addr = BASE;
        #1 chk("R4 no strobe", io_rdata, 0);

        // R5: a write keeps the status byte
        wr(BASE);
        rd(BASE, d);
        chk("R5 after write", d, 8'h10);
        repeat (2 * P) @(negedge clk);

        // R6 R7: held strobe, then the trailing edge
        @(negedge clk);
        io_addr = BASE; io_wr = 1'b1;
        n = 0;
        repeat (3) begin
            @(negedge clk);
            if (rc_discharge) n++;
        end
        chk("R6 no pulse while held", n, 0);
        io_wr = 1'b0;
        count_high(n);
        chk("R7 pulse width", n, P);

        // R9: a write elsewhere starts nothing
        wr(BASE + 3);
        count_high(n);
        chk("R9 other address", n, 0);

        // R8: retrigger on the cycle after launch
        wr(BASE);
        @(negedge clk);
        chk("R8 first pulse up", rc_discharge, 1);
        io_addr = BASE; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        chk("R8 still high", rc_discharge, 1);
        count_high(n);
        chk("R8 reloaded width", n, P);

        // R11: clearing the enable during a pulse
        wr(BASE);
        repeat (3) @(negedge clk);
        act_wr = 1'b1; act_wdata = 1'b0;
        @(negedge clk);
        act_wr = 1'b0;
        chk("R11 one cycle lag", rc_discharge, 1);
        @(negedge clk);
        chk("R11 pulse stopped", rc_discharge, 0);

        // R11: disabled reads and writes
        rd(BASE, d);
        chk("R11 read disabled", d, 0);
        wr(BASE);
        count_high(n);
        chk("R11 write disabled", n, 0);

        // R10: same-cycle writes, the activate value wins
        @(negedge clk);
        act_wr = 1'b1; act_wdata = 1'b1; pwr_wr = 1'b1; pwr_en_bit = 1'b0;
        @(negedge clk);
        act_wr = 1'b0; pwr_wr = 1'b0;
        chk("R10 activate wins", port_active, 1);
        @(negedge clk);
        pwr_wr = 1'b1; pwr_en_bit = 1'b0;
        @(negedge clk);
        pwr_wr = 1'b0;
        chk("R10 pwr clear", port_active, 0);
        set_act(1'b1);
        chk("R10 act set", port_active, 1);

        report();
        $finish;
    end

endmodule